// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Autovector Generation

This block gathers thirteen level-sensitive interrupt inputs, numbered 1 to 13, and presents one request to the processor: a 3-bit interrupt level and an 8-bit vector. Each source owns an 8-bit control byte. Bit 7 selects autovectoring. Bits 4:2 give the level. Bits 1:0 give a sub-priority within that level. Bits 4:0 taken together form the arbitration weight.

A mask register blocks sources; a 1 in a mask bit blocks that source. A pending view shows the live state of the source inputs. The active set is every pending source that is not masked. The active source with the largest weight wins. If that weight is under 4, nothing is presented.

The winner's vector is either an autovector or a value held in a vector register. Three sources have their own vector registers: a watchdog source and two serial-port sources. Any other source that is not autovectored gets the fixed vector 0x0F. Software writes the configuration through a simple write port and reads it back through a combinational read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: On synchronous reset the outputs are level 0 and vector 0, and the registers load these values. Mask: 0x3FFE. Control bytes for sources 1 to 7: 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C. Source 8: 0x1C. Sources 9 to 11: 0x80. Sources 12 and 13: 0x00. Watchdog vector and both serial vectors: 0x0F.
- R2: Pending bit i mirrors input `irq_src[i]`. A source is active only when it is pending and its mask bit is 0. A masked source never drives the outputs.
- R3: Among active sources, the one whose control bits 4:0 are largest wins.
- R4: When two or more active sources share the largest weight, the lowest-numbered one wins.
- R5: If the winning weight is below 4, or no source is active, the outputs are level 0 and vector 0.
- R6: The output level equals control bits 4:2 of the winner.
- R7: If control bit 7 of the winner is 1, the vector is 24 plus the output level.
- R8: If control bit 7 of the winner is 0, the vector comes from one of these places:
  - source 8 uses the watchdog vector register;
  - source 12 uses serial vector 0;
  - source 13 uses serial vector 1;
  - every other source uses 0x0F.
- R9: The level and vector outputs are registered. They reflect a change of source inputs, mask or control bytes exactly one clock edge after the change becomes visible. A register write takes effect at the edge where `cfg_we` is sampled, so the outputs follow at the edge after that.
- R10: Source index 0 does not exist. `irq_src[0]` has no effect, and pending bit 0 and mask bit 0 always read as 0.
- R11: The register addresses, on 5 bits, are as follows:
  - 0x01 to 0x0D: the control byte of sources 1 to 13, taken from wdata[7:0];
  - 0x10: the mask, taken from wdata[13:1], with bits 15:14 and bit 0 reading 0;
  - 0x11: pending, read-only;
  - 0x12: the watchdog vector;
  - 0x13: serial vector 0;
  - 0x14: serial vector 1.

  A write takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 14 | Level-sensitive source inputs; bit i is source i, bit 0 unused |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq_level | output | 3 | Registered interrupt level to the processor, 0 means none |
| irq_vector | output | 8 | Registered interrupt vector to the processor |

## Verification
The bench builds the controller with its default parameters: thirteen sources, a weight floor of 4, and the watchdog and serial vectors bound to sources 8, 12 and 13. These values put several cases within reach:
- the floor boundary at weight 4 against weight 3;
- a tie broken only by source number, set up so that the losing source would produce a different vector;
- every vector-register path, together with the 0x0F fallback.

A scoreboard model built from the requirements predicts level and vector after each stimulus. Direct checks cover register readback and the one-edge output latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CTL_W      = 8;
    localparam int WEIGHT_W   = 5;
    localparam int LEVEL_W    = 3;
    localparam int VEC_W      = 8;
    localparam int IDX_W      = 5;
    localparam int ADDR_W     = 5;

    localparam int CTL_AUTO_BIT = 7;
    localparam int CTL_LVL_LSB  = 2;

    localparam logic [ADDR_W-1:0] A_MASK = 5'h10;
    localparam logic [ADDR_W-1:0] A_PEND = 5'h11;
    localparam logic [ADDR_W-1:0] A_WDV  = 5'h12;
    localparam logic [ADDR_W-1:0] A_UV0  = 5'h13;
    localparam logic [ADDR_W-1:0] A_UV1  = 5'h14;

    localparam logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F;

    typedef logic [CTL_W-1:0] ctl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        ctl_t             ctl;
    } win_t;

    function automatic ctl_t ctl_reset_val(input int src);
        ctl_t v;
        if (src >= 1 && src <= 7)       v = ctl_t'(src * 4);
        else if (src == 8)              v = 8'h1C;
        else if (src >= 9 && src <= 11) v = 8'h80;
        else                            v = 8'h00;
        return v;
    endfunction

    function automatic logic [WEIGHT_W-1:0] weight_of(input ctl_t c);
        return c[WEIGHT_W-1:0];
    endfunction

    function automatic logic [LEVEL_W-1:0] level_of(input ctl_t c);
        return c[CTL_LVL_LSB +: LEVEL_W];
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int DATA_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_SRC:0][CTL_W-1:0]    ctl_o,
    output logic [NUM_SRC:0]               mask_o,
    output logic [VEC_W-1:0]               wdv_o,
    output logic [VEC_W-1:0]               uv0_o,
    output logic [VEC_W-1:0]               uv1_o
);

    logic [NUM_SRC:1] mask_q;

    assign ctl_o[0]  = '0;
    assign mask_o    = {mask_q, 1'b0};

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_ctl
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        ctl_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= ctl_reset_val(g);
            else if (wr_en && wr_addr == MY_ADDR)
                q <= wr_data[CTL_W-1:0];
        end
        assign ctl_o[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            wdv_o  <= FALLBACK_VEC;
            uv0_o  <= FALLBACK_VEC;
            uv1_o  <= FALLBACK_VEC;
        end else if (wr_en) begin
            case (wr_addr)
                A_MASK:  mask_q <= wr_data[NUM_SRC:1];
                A_WDV:   wdv_o  <= wr_data[VEC_W-1:0];
                A_UV0:   uv0_o  <= wr_data[VEC_W-1:0];
                A_UV1:   uv1_o  <= wr_data[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    // A control-byte write lands in the addressed register on the next edge.
    p_ctl_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(3)) |=> (ctl_o[3] == $past(wr_data[CTL_W-1:0])));

    // Slot 0 is never maskable state.
    p_mask_slot0_r10: assert property (@(posedge clk) disable iff (rst)
        mask_o[0] == 1'b0);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int FLOOR   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC:0]            active,
    input  logic [NUM_SRC:0][CTL_W-1:0] ctl,
    output win_t                        win
);

    logic [WEIGHT_W-1:0] best_w;
    logic [IDX_W-1:0]    best_i;
    ctl_t                best_c;

    // Strict comparison keeps the earliest (lowest-numbered) source on a tie.
    always_comb begin
        best_w = '0;
        best_i = '0;
        best_c = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && weight_of(ctl[i]) > best_w) begin
                best_w = weight_of(ctl[i]);
                best_i = IDX_W'(i);
                best_c = ctl[i];
            end
        end
        win.valid = (best_w >= WEIGHT_W'(FLOOR));
        win.idx   = best_i;
        win.ctl   = best_c;
    end

    p_winner_active_r2: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> active[win.idx]);

    p_no_slot0_r10: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.idx != '0));

    p_winner_ctl_r3: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.ctl == ctl[win.idx]));

endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen
    import irqc_pkg::*;
#(
    parameter int WDOG_SRC  = 8,
    parameter int UART0_SRC = 12,
    parameter int UART1_SRC = 13,
    parameter int AUTO_BASE = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  win_t               win,
    input  logic [VEC_W-1:0]   wdv,
    input  logic [VEC_W-1:0]   uv0,
    input  logic [VEC_W-1:0]   uv1,
    output logic [LEVEL_W-1:0] level_q,
    output logic [VEC_W-1:0]   vector_q
);

    logic [LEVEL_W-1:0] lvl_d;
    logic [VEC_W-1:0]   vec_d;

    always_comb begin
        lvl_d = '0;
        vec_d = '0;
        if (win.valid) begin
            lvl_d = level_of(win.ctl);
            if (win.ctl[CTL_AUTO_BIT])
                vec_d = VEC_W'(AUTO_BASE) + VEC_W'(lvl_d);
            else if (win.idx == IDX_W'(WDOG_SRC))
                vec_d = wdv;
            else if (win.idx == IDX_W'(UART0_SRC))
                vec_d = uv0;
            else if (win.idx == IDX_W'(UART1_SRC))
                vec_d = uv1;
            else
                vec_d = FALLBACK_VEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            vector_q <= '0;
        end else begin
            level_q  <= lvl_d;
            vector_q <= vec_d;
        end
    end

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (level_q == '0) |-> (vector_q == '0));

    p_autovec_r7: assert property (@(posedge clk) disable iff (rst)
        (win.valid && win.ctl[CTL_AUTO_BIT]) |=>
            (vector_q == VEC_W'(AUTO_BASE) + VEC_W'(level_q)));

    p_level_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        win.valid |=> (level_q != '0));

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        !win.valid |=> (level_q == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 13,
    parameter int DATA_W    = 16,
    parameter int FLOOR     = 4,
    parameter int WDOG_SRC  = 8,
    parameter int UART0_SRC = 12,
    parameter int UART1_SRC = 13,
    parameter int AUTO_BASE = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC:0]    irq_src,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [LEVEL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]    irq_vector
);

    logic [NUM_SRC:0][CTL_W-1:0] ctl;
    logic [NUM_SRC:0]            mask;
    logic [NUM_SRC:0]            pend;
    logic [NUM_SRC:0]            active;
    logic [VEC_W-1:0]            wdv, uv0, uv1;
    win_t                        win;

    assign pend   = {irq_src[NUM_SRC:1], 1'b0};
    assign active = pend & ~mask;

    irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .ctl_o   (ctl),
        .mask_o  (mask),
        .wdv_o   (wdv),
        .uv0_o   (uv0),
        .uv1_o   (uv1)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .FLOOR(FLOOR)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .ctl    (ctl),
        .win    (win)
    );

    irqc_vecgen #(
        .WDOG_SRC  (WDOG_SRC),
        .UART0_SRC (UART0_SRC),
        .UART1_SRC (UART1_SRC),
        .AUTO_BASE (AUTO_BASE)
    ) u_vec (
        .clk      (clk),
        .rst      (rst),
        .win      (win),
        .wdv      (wdv),
        .uv0      (uv0),
        .uv1      (uv1),
        .level_q  (irq_level),
        .vector_q (irq_vector)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr >= ADDR_W'(1) && rd_addr <= ADDR_W'(NUM_SRC))
            rd_data = DATA_W'(ctl[rd_addr]);
        else begin
            case (rd_addr)
                A_MASK:  rd_data = DATA_W'(mask);
                A_PEND:  rd_data = DATA_W'(pend);
                A_WDV:   rd_data = DATA_W'(wdv);
                A_UV0:   rd_data = DATA_W'(uv0);
                A_UV1:   rd_data = DATA_W'(uv1);
                default: rd_data = '0;
            endcase
        end
    end

    // Any masked source must not be the one presented.
    p_masked_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> (irq_level == '0 && irq_vector == '0));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] irq_src = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state built from the requirements
    logic [7:0]  m_ctl [0:13];
    logic [13:0] m_mask;
    logic [7:0]  m_wdv, m_uv0, m_uv1;

    logic [10:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] model_out(input logic [13:0] src);
        logic [4:0] bw;
        int bi;
        logic [2:0] l;
        logic [7:0] v;
        bw = 0; bi = 0; l = 0; v = 0;
        for (int i = 1; i <= 13; i++)
            if (src[i] && !m_mask[i] && m_ctl[i][4:0] > bw) begin
                bw = m_ctl[i][4:0]; bi = i;
            end
        if (bw >= 5'd4) begin
            l = m_ctl[bi][4:2];
            if (m_ctl[bi][7]) v = 8'd24 + {5'd0, l};
            else if (bi == 8)  v = m_wdv;
            else if (bi == 12) v = m_uv0;
            else if (bi == 13) v = m_uv1;
            else               v = 8'h0F;
        end
        return {l, v};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 5'd1 && a <= 5'd13) m_ctl[a] = d[7:0];
        else if (a == 5'h10) m_mask = {d[13:1], 1'b0};
        else if (a == 5'h12) m_wdv = d[7:0];
        else if (a == 5'h13) m_uv0 = d[7:0];
        else if (a == 5'h14) m_uv1 = d[7:0];
    endtask

    task automatic set_src(input logic [13:0] v);
        @(negedge clk);
        irq_src = v;
    endtask

    // Driver side of the scoreboard: outputs settle one edge after the last change
    task automatic expect_out(input string tag);
        @(posedge clk);
        #1;
        exp_q.push_back(model_out(irq_src));
        tag_q.push_back(tag);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [15:0] e);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, e);
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [10:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {5'd0, irq_level, irq_vector}, {5'd0, e});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i <= 13; i++) begin
            if (i >= 1 && i <= 7) m_ctl[i] = 8'(i * 4);
            else if (i == 8) m_ctl[i] = 8'h1C;
            else if (i >= 9 && i <= 11) m_ctl[i] = 8'h80;
            else m_ctl[i] = 8'h00;
        end
        m_mask = 14'h3FFE; m_wdv = 8'h0F; m_uv0 = 8'h0F; m_uv1 = 8'h0F;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 level", {13'd0, irq_level}, 16'd0);
        check("R1 vector", {8'd0, irq_vector}, 16'd0);
        rd_chk("R1 mask", 5'h10, 16'h3FFE);
        rd_chk("R1 ctl1", 5'h01, 16'h0004);
        rd_chk("R1 ctl7", 5'h07, 16'h001C);
        rd_chk("R1 ctl8", 5'h08, 16'h001C);
        rd_chk("R1 ctl9", 5'h09, 16'h0080);
        rd_chk("R1 ctl13", 5'h0D, 16'h0000);
        rd_chk("R1 wdv", 5'h12, 16'h000F);

        // R2: pending visible but masked source stays silent
        set_src(14'h0008);
        expect_out("R2 masked source");
        rd_chk("R2 pending", 5'h11, 16'h0008);
        wr(5'h10, 16'h0000);
        expect_out("R2 R6 R8 unmasked src3");

        // R5: boundary weight 4 wins, 3 does not
        set_src(14'h0002);
        expect_out("R5 weight 4 presented");
        wr(5'h01, 16'h0003);
        expect_out("R5 weight 3 suppressed");
        check("R5 level zero", {13'd0, irq_level}, 16'd0);

        // R4: tie on weight 0x14, src6 autovectored so a wrong pick shows
        wr(5'h06, 16'h0094);
        set_src(14'h0060);
        expect_out("R4 tie lowest wins");
        check("R4 vector", {8'd0, irq_vector}, 16'h000F);

        // R3: highest weight wins
        set_src(14'h0090);
        expect_out("R3 highest weight");
        check("R3 level", {13'd0, irq_level}, 16'd7);

        // R2: masking the winner hands over to the next one
        wr(5'h10, 16'h0080);
        expect_out("R2 masked winner");
        check("R2 level after mask", {13'd0, irq_level}, 16'd4);
        wr(5'h10, 16'h0000);

        // R7: autovector
        wr(5'h09, 16'h008B);
        set_src(14'h0200);
        expect_out("R7 autovector");
        check("R7 vector", {8'd0, irq_vector}, 16'd26);

        // R8: vector registers
        wr(5'h12, 16'h0040);
        set_src(14'h0100);
        expect_out("R8 watchdog vector");
        wr(5'h0C, 16'h0010);
        wr(5'h13, 16'h0041);
        set_src(14'h1000);
        expect_out("R8 serial0 vector");
        wr(5'h0D, 16'h0018);
        wr(5'h14, 16'h0042);
        set_src(14'h3000);
        expect_out("R8 serial1 vector");
        check("R8 serial1 value", {8'd0, irq_vector}, 16'h0042);

        // R10: input bit 0 is inert
        set_src(14'h0001);
        expect_out("R10 slot0 input");
        rd_chk("R10 pending bit0", 5'h11, 16'h0000);
        wr(5'h10, 16'hFFFF);
        rd_chk("R10 R11 mask readback", 5'h10, 16'h3FFE);
        wr(5'h10, 16'h0000);

        // R9: exactly one edge of latency after a source change
        set_src(14'h0000);
        @(negedge clk);
        irq_src = 14'h0010;
        #1;
        check("R9 before edge", {13'd0, irq_level}, 16'd0);
        @(negedge clk);
        check("R9 after edge", {13'd0, irq_level}, 16'd4);
        // write latency: effect two edges after strobe driven
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'h04; cfg_wdata = 16'h0098;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 write not yet", {8'd0, irq_vector}, 16'h000F);
        m_ctl[4] = 8'h98;
        @(negedge clk);
        check("R9 write applied", {8'd0, irq_vector}, 16'd30);

        @(negedge clk);
        @(negedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule